// File: doc/BRIEF.md
# Mailbox Queue Context Registers

This block holds the control state of one mailbox context. A context pairs two circular queues in shared memory. In the command queue the host produces entries and the device consumes them. In the response queue the device produces entries and the host consumes them. The host programs the context through a single-cycle register port. That port covers each queue's 36-bit base address and element count, the indices it owns, the control bits, the priority, the error flags and the doorbells. The device side moves the indices it owns through a separate increment port and rings the response doorbell with a pulse.

Every index is one bit wider than the position field. The extra top bit is a wrap flag that inverts each time the position passes the end of a queue whose length may be any count up to the maximum. The block derives empty, full and occupancy for both queues from these indices. It drives a level interrupt toward the host while a response doorbell is pending, its interrupt enable is set and the context is enabled. A four-step reset sequence started by one register write clears out stale commands and responses.

Top module: `mbox_ctx_regs`

## Requirements
- R1: After reset the control word, priority, error flags and doorbell status read zero. All four indices and both base addresses are zero, both sizes read MAX_ELEMS, and both queues report empty.
- R2: The control word at word address 0 holds four bits: bit 0 context enable, bit 1 command-doorbell interrupt enable, bit 2 response-doorbell interrupt enable, bit 3 ring-on-tail enable. It reads back as written. The priority word at address 1 reads back and drives ctx_priority.
- R3: An index holds the position in bits [POS_W-1:0] and the wrap flag in bit POS_W. An advance that reaches or passes the queue size subtracts the size from the position and inverts the wrap flag.
- R4: A queue is empty when head equals tail including the wrap flag. It is full when the positions match and the wrap flags differ. Occupancy is tail minus head modulo the size, and equals the size when full.
- R5: A size write (command 8, response 13) of zero or above MAX_ELEMS leaves the size unchanged and sets error bit 0.
- R6: The base address is {high[3:0], low[31:0]}, with low at address 6 or 11 and high at 7 or 12. A high-word write with any bit of [31:4] set is ignored and sets error bit 1.
- R7: Every accepted write to a queue's low base, high base or size forces that queue's head and tail to zero.
- R8: Writing 1 to bit 0 of address 2 starts a sequence, one step per clock: clear the context enable, zero the command head and tail, zero the response head and tail, set the context enable. The host cannot change the enable bit while the sequence runs.
- R9: The host writes the command tail (address 9) and the response head (address 14). The command head (10) and response tail (15) are read-only, and writes to them are ignored.
- R10: A device increment with dev_inc_sel 0 advances the command head, and with 1 advances the response tail. The amount is clamped to the command occupancy or to the response free space, and a clamp sets error bit 2. Increments are ignored while the context enable is clear.
- R11: Doorbell status (address 4): bit 0 is set by a command-tail write while ring-on-tail is enabled, and bit 1 is set by dev_rsp_ring. Writing 1 to the matching bit of address 5 clears it. A set in the same cycle as a clear wins.
- R12: host_irq is high exactly when response doorbell status, its interrupt enable and the context enable are all set. dev_cmd_irq follows the same rule for the command doorbell.
- R13: Error flags (address 3) are sticky and cleared bit by bit by writing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| dev_inc_valid | input | 1 | Device index increment request |
| dev_inc_sel | input | 1 | 0: command head, 1: response tail |
| dev_inc_amt | input | POS_W+1 | Increment amount in elements |
| dev_rsp_ring | input | 1 | Device rings the response doorbell |
| ctx_enable | output | 1 | Context enable |
| ctx_priority | output | PRIO_W | Context priority |
| cmd_base | output | 36 | Command queue base address |
| rsp_base | output | 36 | Response queue base address |
| cmd_head | output | POS_W+1 | Command head index |
| cmd_tail | output | POS_W+1 | Command tail index |
| rsp_head | output | POS_W+1 | Response head index |
| rsp_tail | output | POS_W+1 | Response tail index |
| cmd_occ | output | POS_W+1 | Command queue occupancy |
| rsp_occ | output | POS_W+1 | Response queue occupancy |
| cmd_full | output | 1 | Command queue full |
| cmd_empty | output | 1 | Command queue empty |
| rsp_full | output | 1 | Response queue full |
| rsp_empty | output | 1 | Response queue empty |
| dev_cmd_irq | output | 1 | Command doorbell interrupt toward the device |
| host_irq | output | 1 | Response doorbell interrupt toward the host |

## Verification
Two functions collide when the device rings the response doorbell in the same clock in which the host writes 1 to clear it. The bench drives dev_rsp_ring and the clear write on one edge. It then reads the status word and expects bit 1 still set, because the new event must not be lost. A second overlap comes from device increments arriving while the reset sequence or a disabled context holds the indices. There the bench expects the head unchanged and no clamp error.

// File: rtl/mbox_ctx_pkg.sv
package mbox_ctx_pkg;

    localparam int DEF_POS_W     = 10;
    localparam int DEF_MAX_ELEMS = 1000;
    localparam int DEF_PRIO_W    = 4;
    localparam int DEF_ADDR_W    = 5;
    localparam int BASE_W        = 36;
    localparam int BASE_HI_W     = BASE_W - 32;

    // register word addresses
    localparam int RA_CTRL     = 0;
    localparam int RA_PRIO     = 1;
    localparam int RA_RESET    = 2;
    localparam int RA_ERR      = 3;
    localparam int RA_DB_STAT  = 4;
    localparam int RA_DB_CLR   = 5;
    localparam int RA_CMD_LO   = 6;
    localparam int RA_CMD_HI   = 7;
    localparam int RA_CMD_SIZE = 8;
    localparam int RA_CMD_TAIL = 9;
    localparam int RA_CMD_HEAD = 10;
    localparam int RA_RSP_LO   = 11;
    localparam int RA_RSP_HI   = 12;
    localparam int RA_RSP_SIZE = 13;
    localparam int RA_RSP_HEAD = 14;
    localparam int RA_RSP_TAIL = 15;

    localparam int NUM_DB = 2;
    localparam int DB_CMD = 0;
    localparam int DB_RSP = 1;

    typedef struct packed {
        logic ring_en;
        logic rsp_ie;
        logic cmd_ie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic inc_clamp;
        logic addr_rej;
        logic size_rej;
    } err_t;

    typedef struct packed {
        logic lo;
        logic hi;
        logic size;
        logic host_ptr;
    } qwr_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_OFF,
        SEQ_CMD,
        SEQ_RSP,
        SEQ_ON
    } seq_state_e;

endpackage

// File: rtl/mbox_queue_ctl.sv
module mbox_queue_ctl
    import mbox_ctx_pkg::*;
#(
    parameter int POS_W          = DEF_POS_W,
    parameter int MAX_ELEMS      = DEF_MAX_ELEMS,
    parameter bit HOST_OWNS_TAIL = 1'b1,
    localparam int IDX_W         = POS_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  qwr_t               wr,
    input  logic [31:0]        wdata,
    input  logic               dev_adv,
    input  logic [IDX_W-1:0]   dev_amt,
    input  logic               zero_ptrs,
    output logic [IDX_W-1:0]   head,
    output logic [IDX_W-1:0]   tail,
    output logic [BASE_W-1:0]  base,
    output logic [IDX_W-1:0]   size,
    output logic [IDX_W-1:0]   occ,
    output logic               full,
    output logic               empty,
    output logic               size_rej,
    output logic               addr_rej,
    output logic               inc_clamp
);

    logic [IDX_W-1:0]     head_q, tail_q, size_q;
    logic [31:0]          base_lo_q;
    logic [BASE_HI_W-1:0] base_hi_q;
    logic                 size_ok, hi_ok, prog;
    logic [IDX_W-1:0]     limit, amt_eff, dev_ptr, dev_next;

    function automatic logic [IDX_W-1:0] occ_of(input logic [IDX_W-1:0] h,
                                                input logic [IDX_W-1:0] t,
                                                input logic [IDX_W-1:0] sz);
        logic [IDX_W-1:0] hp, tp;
        hp = {1'b0, h[POS_W-1:0]};
        tp = {1'b0, t[POS_W-1:0]};
        if (h[POS_W] == t[POS_W]) return tp - hp;
        return sz - hp + tp;
    endfunction

    function automatic logic [IDX_W-1:0] advance(input logic [IDX_W-1:0] idx,
                                                 input logic [IDX_W-1:0] n,
                                                 input logic [IDX_W-1:0] sz);
        logic [IDX_W:0] sum;
        sum = {2'b00, idx[POS_W-1:0]} + {1'b0, n};
        if (sum >= {1'b0, sz}) begin
            sum = sum - {1'b0, sz};
            return {~idx[POS_W], sum[POS_W-1:0]};
        end
        return {idx[POS_W], sum[POS_W-1:0]};
    endfunction

    assign size_ok  = (wdata != 32'd0) && (wdata <= 32'(MAX_ELEMS));
    assign hi_ok    = (wdata[31:BASE_HI_W] == '0);
    assign size_rej = wr.size && !size_ok;
    assign addr_rej = wr.hi && !hi_ok;
    assign prog     = wr.lo | (wr.hi & hi_ok) | (wr.size & size_ok);

    assign occ   = occ_of(head_q, tail_q, size_q);
    assign empty = (head_q == tail_q);
    assign full  = (head_q[POS_W-1:0] == tail_q[POS_W-1:0]) &&
                   (head_q[POS_W] != tail_q[POS_W]);

    // the side the device owns, and how far it may move
    generate
        if (HOST_OWNS_TAIL) begin : g_dev_head
            assign dev_ptr = head_q;
            assign limit   = occ;
        end else begin : g_dev_tail
            assign dev_ptr = tail_q;
            assign limit   = size_q - occ;
        end
    endgenerate

    assign amt_eff   = (dev_amt > limit) ? limit : dev_amt;
    assign inc_clamp = dev_adv && (dev_amt > limit);
    assign dev_next  = advance(dev_ptr, amt_eff, size_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q    <= '0;
            tail_q    <= '0;
            size_q    <= IDX_W'(MAX_ELEMS);
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else begin
            if (wr.lo)             base_lo_q <= wdata;
            if (wr.hi && hi_ok)    base_hi_q <= wdata[BASE_HI_W-1:0];
            if (wr.size && size_ok) size_q   <= wdata[IDX_W-1:0];
            if (zero_ptrs || prog) begin
                head_q <= '0;
                tail_q <= '0;
            end else if (HOST_OWNS_TAIL) begin
                if (wr.host_ptr) tail_q <= wdata[IDX_W-1:0];
                if (dev_adv)     head_q <= dev_next;
            end else begin
                if (wr.host_ptr) head_q <= wdata[IDX_W-1:0];
                if (dev_adv)     tail_q <= dev_next;
            end
        end
    end

    assign head = head_q;
    assign tail = tail_q;
    assign size = size_q;
    assign base = {base_hi_q, base_lo_q};

endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    input  logic ctx_en,
    output logic status,
    output logic irq
);

    logic status_q;

    // a new ring beats a clear arriving in the same cycle
    always_ff @(posedge clk) begin
        if (rst)      status_q <= 1'b0;
        else if (set) status_q <= 1'b1;
        else if (clr) status_q <= 1'b0;
    end

    assign status = status_q;
    assign irq    = status_q & irq_en & ctx_en;

endmodule

// File: rtl/mbox_reset_seq.sv
module mbox_reset_seq
    import mbox_ctx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic en_off,
    output logic zero_cmd,
    output logic zero_rsp,
    output logic en_on
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start) state_d = SEQ_OFF;
            SEQ_OFF:  state_d = SEQ_CMD;
            SEQ_CMD:  state_d = SEQ_RSP;
            SEQ_RSP:  state_d = SEQ_ON;
            SEQ_ON:   state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    assign busy     = (state_q != SEQ_IDLE);
    assign en_off   = (state_q == SEQ_OFF);
    assign zero_cmd = (state_q == SEQ_CMD);
    assign zero_rsp = (state_q == SEQ_RSP);
    assign en_on    = (state_q == SEQ_ON);

endmodule

// File: rtl/mbox_ctx_regs.sv
module mbox_ctx_regs
    import mbox_ctx_pkg::*;
#(
    parameter int POS_W     = DEF_POS_W,
    parameter int MAX_ELEMS = DEF_MAX_ELEMS,
    parameter int PRIO_W    = DEF_PRIO_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    localparam int IDX_W    = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dev_inc_valid,
    input  logic              dev_inc_sel,
    input  logic [IDX_W-1:0]  dev_inc_amt,
    input  logic              dev_rsp_ring,
    output logic              ctx_enable,
    output logic [PRIO_W-1:0] ctx_priority,
    output logic [BASE_W-1:0] cmd_base,
    output logic [BASE_W-1:0] rsp_base,
    output logic [IDX_W-1:0]  cmd_head,
    output logic [IDX_W-1:0]  cmd_tail,
    output logic [IDX_W-1:0]  rsp_head,
    output logic [IDX_W-1:0]  rsp_tail,
    output logic [IDX_W-1:0]  cmd_occ,
    output logic [IDX_W-1:0]  rsp_occ,
    output logic              cmd_full,
    output logic              cmd_empty,
    output logic              rsp_full,
    output logic              rsp_empty,
    output logic              dev_cmd_irq,
    output logic              host_irq
);

    ctrl_t              ctrl_q;
    err_t               err_q, err_set;
    logic [PRIO_W-1:0]  prio_q;
    qwr_t               cmd_wr, rsp_wr;
    logic [IDX_W-1:0]   cmd_size, rsp_size;
    logic               cmd_size_rej, cmd_addr_rej, cmd_clamp;
    logic               rsp_size_rej, rsp_addr_rej, rsp_clamp;
    logic               seq_start, seq_busy, seq_en_off, seq_zero_cmd, seq_zero_rsp, seq_en_on;
    logic [NUM_DB-1:0]  db_set, db_clr, db_ie, db_st, db_irq;

    function automatic logic hit(input logic w, input logic [ADDR_W-1:0] a, input int ra);
        return w && (a == ADDR_W'(ra));
    endfunction

    // ---------------- control, priority, errors ----------------
    assign seq_start = hit(reg_wr, reg_addr, RA_RESET) && reg_wdata[0] && !seq_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            prio_q <= '0;
        end else begin
            if (hit(reg_wr, reg_addr, RA_CTRL)) begin
                ctrl_q.cmd_ie  <= reg_wdata[1];
                ctrl_q.rsp_ie  <= reg_wdata[2];
                ctrl_q.ring_en <= reg_wdata[3];
                if (!seq_busy) ctrl_q.en <= reg_wdata[0];
            end
            if (seq_en_off) ctrl_q.en <= 1'b0;
            if (seq_en_on)  ctrl_q.en <= 1'b1;
            if (hit(reg_wr, reg_addr, RA_PRIO)) prio_q <= reg_wdata[PRIO_W-1:0];
        end
    end

    assign err_set.size_rej  = cmd_size_rej | rsp_size_rej;
    assign err_set.addr_rej  = cmd_addr_rej | rsp_addr_rej;
    assign err_set.inc_clamp = cmd_clamp | rsp_clamp;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (hit(reg_wr, reg_addr, RA_ERR)) begin
            err_q <= (err_q & ~err_t'(reg_wdata[2:0])) | err_set;
        end else begin
            err_q <= err_q | err_set;
        end
    end

    // ---------------- reset sequence ----------------
    mbox_reset_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .busy     (seq_busy),
        .en_off   (seq_en_off),
        .zero_cmd (seq_zero_cmd),
        .zero_rsp (seq_zero_rsp),
        .en_on    (seq_en_on)
    );

    // ---------------- queues ----------------
    assign cmd_wr.lo       = hit(reg_wr, reg_addr, RA_CMD_LO);
    assign cmd_wr.hi       = hit(reg_wr, reg_addr, RA_CMD_HI);
    assign cmd_wr.size     = hit(reg_wr, reg_addr, RA_CMD_SIZE);
    assign cmd_wr.host_ptr = hit(reg_wr, reg_addr, RA_CMD_TAIL);
    assign rsp_wr.lo       = hit(reg_wr, reg_addr, RA_RSP_LO);
    assign rsp_wr.hi       = hit(reg_wr, reg_addr, RA_RSP_HI);
    assign rsp_wr.size     = hit(reg_wr, reg_addr, RA_RSP_SIZE);
    assign rsp_wr.host_ptr = hit(reg_wr, reg_addr, RA_RSP_HEAD);

    mbox_queue_ctl #(
        .POS_W(POS_W), .MAX_ELEMS(MAX_ELEMS), .HOST_OWNS_TAIL(1'b1)
    ) u_cmdq (
        .clk       (clk),
        .rst       (rst),
        .wr        (cmd_wr),
        .wdata     (reg_wdata),
        .dev_adv   (dev_inc_valid && !dev_inc_sel && ctrl_q.en),
        .dev_amt   (dev_inc_amt),
        .zero_ptrs (seq_zero_cmd),
        .head      (cmd_head),
        .tail      (cmd_tail),
        .base      (cmd_base),
        .size      (cmd_size),
        .occ       (cmd_occ),
        .full      (cmd_full),
        .empty     (cmd_empty),
        .size_rej  (cmd_size_rej),
        .addr_rej  (cmd_addr_rej),
        .inc_clamp (cmd_clamp)
    );

    mbox_queue_ctl #(
        .POS_W(POS_W), .MAX_ELEMS(MAX_ELEMS), .HOST_OWNS_TAIL(1'b0)
    ) u_rspq (
        .clk       (clk),
        .rst       (rst),
        .wr        (rsp_wr),
        .wdata     (reg_wdata),
        .dev_adv   (dev_inc_valid && dev_inc_sel && ctrl_q.en),
        .dev_amt   (dev_inc_amt),
        .zero_ptrs (seq_zero_rsp),
        .head      (rsp_head),
        .tail      (rsp_tail),
        .base      (rsp_base),
        .size      (rsp_size),
        .occ       (rsp_occ),
        .full      (rsp_full),
        .empty     (rsp_empty),
        .size_rej  (rsp_size_rej),
        .addr_rej  (rsp_addr_rej),
        .inc_clamp (rsp_clamp)
    );

    // ---------------- doorbells ----------------
    assign db_set[DB_CMD] = cmd_wr.host_ptr && ctrl_q.ring_en;
    assign db_set[DB_RSP] = dev_rsp_ring;
    assign db_ie[DB_CMD]  = ctrl_q.cmd_ie;
    assign db_ie[DB_RSP]  = ctrl_q.rsp_ie;

    generate
        for (genvar i = 0; i < NUM_DB; i++) begin : g_db
            assign db_clr[i] = hit(reg_wr, reg_addr, RA_DB_CLR) && reg_wdata[i];
            mbox_doorbell u_db (
                .clk    (clk),
                .rst    (rst),
                .set    (db_set[i]),
                .clr    (db_clr[i]),
                .irq_en (db_ie[i]),
                .ctx_en (ctrl_q.en),
                .status (db_st[i]),
                .irq    (db_irq[i])
            );
        end
    endgenerate

    // ---------------- readback ----------------
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(RA_CTRL):     reg_rdata = 32'(ctrl_q);
            ADDR_W'(RA_PRIO):     reg_rdata = 32'(prio_q);
            ADDR_W'(RA_ERR):      reg_rdata = 32'(err_q);
            ADDR_W'(RA_DB_STAT):  reg_rdata = 32'(db_st);
            ADDR_W'(RA_CMD_LO):   reg_rdata = cmd_base[31:0];
            ADDR_W'(RA_CMD_HI):   reg_rdata = 32'(cmd_base[BASE_W-1:32]);
            ADDR_W'(RA_CMD_SIZE): reg_rdata = 32'(cmd_size);
            ADDR_W'(RA_CMD_TAIL): reg_rdata = 32'(cmd_tail);
            ADDR_W'(RA_CMD_HEAD): reg_rdata = 32'(cmd_head);
            ADDR_W'(RA_RSP_LO):   reg_rdata = rsp_base[31:0];
            ADDR_W'(RA_RSP_HI):   reg_rdata = 32'(rsp_base[BASE_W-1:32]);
            ADDR_W'(RA_RSP_SIZE): reg_rdata = 32'(rsp_size);
            ADDR_W'(RA_RSP_HEAD): reg_rdata = 32'(rsp_head);
            ADDR_W'(RA_RSP_TAIL): reg_rdata = 32'(rsp_tail);
            default:              reg_rdata = '0;
        endcase
    end

    assign ctx_enable   = ctrl_q.en;
    assign ctx_priority = prio_q;
    assign dev_cmd_irq  = db_irq[DB_CMD];
    assign host_irq     = db_irq[DB_RSP];

endmodule

// File: rtl/mbox_ctx_chk.sv
module mbox_ctx_chk
    import mbox_ctx_pkg::*;
#(
    parameter int POS_W     = DEF_POS_W,
    parameter int MAX_ELEMS = DEF_MAX_ELEMS,
    parameter int ADDR_W    = DEF_ADDR_W,
    localparam int IDX_W    = POS_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              dev_inc_valid,
    input logic              dev_rsp_ring,
    input logic              ctx_enable,
    input logic [BASE_W-1:0] cmd_base,
    input logic [IDX_W-1:0]  cmd_head,
    input logic [IDX_W-1:0]  cmd_occ,
    input logic [IDX_W-1:0]  rsp_occ,
    input logic              cmd_full,
    input logic              cmd_empty,
    input logic              rsp_full,
    input logic              rsp_empty,
    input logic [1:0]        db_st,
    input logic              seq_busy
);

    // R4
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_full && cmd_empty) && !(rsp_full && rsp_empty));

    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_occ <= IDX_W'(MAX_ELEMS)) && (rsp_occ <= IDX_W'(MAX_ELEMS)));

    // R11
    ring_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        dev_rsp_ring |=> db_st[1]);

    // R6
    hi_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(RA_CMD_HI) && reg_wdata[31:4] != '0)
        |=> $stable(cmd_base));

    // R10
    dev_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctx_enable && dev_inc_valid && !reg_wr && !seq_busy)
        |=> $stable(cmd_head));

    // R8
    seq_end_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(RA_RESET) && reg_wdata[0] && !seq_busy)
        |=> ##4 ctx_enable);

endmodule

bind mbox_ctx_regs mbox_ctx_chk #(
    .POS_W(POS_W), .MAX_ELEMS(MAX_ELEMS), .ADDR_W(ADDR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .dev_inc_valid (dev_inc_valid),
    .dev_rsp_ring  (dev_rsp_ring),
    .ctx_enable    (ctx_enable),
    .cmd_base      (cmd_base),
    .cmd_head      (cmd_head),
    .cmd_occ       (cmd_occ),
    .rsp_occ       (rsp_occ),
    .cmd_full      (cmd_full),
    .cmd_empty     (cmd_empty),
    .rsp_full      (rsp_full),
    .rsp_empty     (rsp_empty),
    .db_st         (db_st),
    .seq_busy      (seq_busy)
);

// File: tb/test_mbox_ctx_regs.sv
module test_mbox_ctx_regs;

    localparam int POS_W = 10;
    localparam int IDX_W = POS_W + 1;
    localparam int MAXE  = 1000;
    localparam int WRAP  = 1 << POS_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [4:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              dev_inc_valid = 1'b0;
    logic              dev_inc_sel = 1'b0;
    logic [IDX_W-1:0]  dev_inc_amt = '0;
    logic              dev_rsp_ring = 1'b0;
    logic              ctx_enable;
    logic [3:0]        ctx_priority;
    logic [35:0]       cmd_base, rsp_base;
    logic [IDX_W-1:0]  cmd_head, cmd_tail, rsp_head, rsp_tail, cmd_occ, rsp_occ;
    logic              cmd_full, cmd_empty, rsp_full, rsp_empty, dev_cmd_irq, host_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mbox_ctx_regs i_mbox_ctx_regs (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a); reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic dev_inc(input logic sel, input int amt);
        @(negedge clk);
        dev_inc_valid = 1'b1; dev_inc_sel = sel; dev_inc_amt = IDX_W'(amt);
        @(posedge clk);
        @(negedge clk);
        dev_inc_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, d);  chk("R1", "ctrl", d, 0);
        rd(3, d);  chk("R1", "err", d, 0);
        rd(4, d);  chk("R1", "db status", d, 0);
        rd(8, d);  chk("R1", "cmd size", d, MAXE);
        rd(13, d); chk("R1", "rsp size", d, MAXE);
        chk("R1", "indices", {cmd_head, cmd_tail, rsp_head, rsp_tail}, 0);
        chk("R1", "empty", {cmd_empty, rsp_empty, cmd_full, rsp_full}, 4'b1100);
        chk("R1", "bases/prio/irq", {cmd_base, rsp_base, ctx_priority, host_irq}, 0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d;
        wr(0, 32'hF); rd(0, d);
        chk("R2", "ctrl readback", d, 32'hF);
        chk("R2", "ctx_enable", ctx_enable, 1);
        wr(1, 32'hA); rd(1, d);
        chk("R2", "prio readback", d, 32'hA);
        chk("R2", "ctx_priority", ctx_priority, 4'hA);
        wr(0, 32'h1);
    endtask

    task automatic t_size;
        logic [31:0] d;
        wr(8, 0); rd(8, d);
        chk("R5", "zero size ignored", d, MAXE);
        rd(3, d); chk("R5", "size err flag", d, 1);
        wr(3, 1); rd(3, d); chk("R13", "err cleared", d, 0);
        wr(13, MAXE + 1); rd(13, d);
        chk("R5", "oversize ignored", d, MAXE);
        rd(3, d); chk("R5", "oversize err", d, 1);
        wr(3, 1);
        wr(8, 5); rd(8, d); chk("R5", "accepted size", d, 5);
        rd(3, d); chk("R5", "no err on good size", d, 0);
    endtask

    task automatic t_base;
        logic [31:0] d;
        wr(7, 32'h5); wr(6, 32'h12345678);
        chk("R6", "cmd base", cmd_base, 36'h512345678);
        wr(7, 32'h15);
        chk("R6", "high reject keeps base", cmd_base, 36'h512345678);
        rd(3, d); chk("R6", "addr err flag", d, 2);
        wr(8, 0);
        rd(3, d); chk("R13", "two flags", d, 3);
        wr(3, 1); rd(3, d); chk("R13", "partial clear", d, 2);
        wr(3, 2); rd(3, d); chk("R13", "all clear", d, 0);
    endtask

    task automatic t_cmd;
        logic [31:0] d;
        wr(9, 3);
        chk("R9", "cmd tail written", cmd_tail, 3);
        chk("R4", "occ 3", {cmd_occ, cmd_empty}, {11'd3, 1'b0});
        wr(10, 2);
        chk("R9", "cmd head read-only", cmd_head, 0);
        dev_inc(0, 2);
        chk("R10", "cmd head advanced", {cmd_head, cmd_occ}, {11'd2, 11'd1});
        wr(9, WRAP + 1);
        chk("R4", "occ across wrap", cmd_occ, 4);
        dev_inc(0, 4);
        chk("R3", "head wraps", cmd_head, WRAP + 1);
        chk("R4", "empty after wrap", {cmd_empty, cmd_occ}, {1'b1, 11'd0});
        wr(9, 1);
        chk("R4", "full", {cmd_full, cmd_empty, cmd_occ}, {1'b1, 1'b0, 11'd5});
        dev_inc(0, 7);
        chk("R10", "clamped to occupancy", {cmd_head, cmd_empty}, {11'd1, 1'b1});
        rd(3, d); chk("R10", "clamp err", d, 4);
        wr(3, 7);
        wr(0, 0);
        dev_inc(0, 1);
        chk("R10", "disabled ignores inc", cmd_head, 1);
        rd(3, d); chk("R10", "disabled no err", d, 0);
        wr(0, 1);
    endtask

    task automatic t_rsp;
        logic [31:0] d;
        wr(13, 3);
        dev_inc(1, 2);
        chk("R10", "rsp tail advanced", {rsp_tail, rsp_occ}, {11'd2, 11'd2});
        wr(14, 1);
        chk("R9", "rsp head written", {rsp_head, rsp_occ}, {11'd1, 11'd1});
        dev_inc(1, 5);
        chk("R10", "clamped to free space", rsp_tail, WRAP + 1);
        chk("R4", "rsp full", {rsp_full, rsp_occ}, {1'b1, 11'd3});
        rd(3, d); chk("R10", "rsp clamp err", d, 4);
        wr(3, 4);
        wr(15, 0);
        chk("R9", "rsp tail read-only", rsp_tail, WRAP + 1);
        wr(11, 32'h1000);
        chk("R7", "base write zeroes", {rsp_head, rsp_tail, rsp_empty}, {22'd0, 1'b1});
        wr(9, 2);
        wr(8, 5);
        chk("R7", "size write zeroes", {cmd_head, cmd_tail}, 0);
    endtask

    task automatic t_doorbell;
        logic [31:0] d;
        wr(0, 32'hF);
        @(negedge clk); dev_rsp_ring = 1'b1;
        @(negedge clk); dev_rsp_ring = 1'b0;
        chk("R12", "host_irq on ring", host_irq, 1);
        rd(4, d); chk("R11", "rsp status", d, 2);
        wr(0, 32'hB); chk("R12", "ie off", host_irq, 0);
        wr(0, 32'hE); chk("R12", "ctx off", host_irq, 0);
        wr(0, 32'hF); chk("R12", "irq back", host_irq, 1);
        wr(5, 2); rd(4, d);
        chk("R11", "w1c clear", {d[1:0], host_irq}, 3'b000);
        @(negedge clk);
        dev_rsp_ring = 1'b1; reg_addr = 5'd5; reg_wdata = 2; reg_wr = 1'b1;
        @(negedge clk);
        dev_rsp_ring = 1'b0; reg_wr = 1'b0;
        rd(4, d); chk("R11", "set beats clear", d, 2);
        wr(5, 3);
        wr(9, 1); rd(4, d);
        chk("R11", "tail ring", {d[1:0], dev_cmd_irq}, 3'b011);
        wr(5, 1);
        wr(0, 32'h7);
        wr(9, 2); rd(4, d);
        chk("R11", "no ring when disabled", {d[1:0], dev_cmd_irq}, 3'b000);
    endtask

    task automatic t_seq;
        wr(0, 1);
        wr(9, 2);
        dev_inc(1, 1);
        wr(2, 1);
        @(negedge clk);
        chk("R8", "step1 enable off", {ctx_enable, cmd_tail}, {1'b0, 11'd2});
        @(negedge clk);
        chk("R8", "step2 cmd zero", {cmd_tail, rsp_tail}, {11'd0, 11'd1});
        @(negedge clk);
        chk("R8", "step3 rsp zero", {rsp_tail, ctx_enable}, {11'd0, 1'b0});
        @(negedge clk);
        chk("R8", "step4 enable on", ctx_enable, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset;
        t_ctrl;
        t_size;
        t_base;
        t_cmd;
        t_rsp;
        t_doorbell;
        t_seq;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule